// File: doc/BRIEF.md
# Virtual Address Segment Translator

This block takes a 32-bit virtual address together with the requester's privilege and error-level state, decides which architectural region the address falls in, and produces a physical address, a read/write permission pair and a status code. Addresses that need no page table (the cached/uncached kernel window, the error-level view of the user region, and everything in the fixed-offset and identity schemes) are translated inside the block. Mapped addresses are forwarded to an external TLB through a one-cycle request pulse, and the TLB's answer is returned with its hit/miss/invalid/modified status recoded onto the block's status field.

A two-bit scheme select, sampled with each request, chooses full TLB translation, a fixed-offset scheme, or pass-through identity. The block accepts one request at a time. Its controller has four states: IDLE (ready, waiting for `req_valid`), ISSUE (TLB request pulse out), WAIT (waiting for the TLB answer) and DONE (result presented). The transitions are IDLE→DONE for a locally translated address, IDLE→ISSUE for a mapped one, ISSUE→DONE or ISSUE→WAIT depending on whether the TLB has answered, WAIT→DONE on the answer, and DONE→IDLE unconditionally.

Top module: `vaseg_xlate`

## Requirements
- R1: With scheme select 2 (identity), every accepted address returns physical address equal to the virtual address, permission 3 (bit0 read, bit1 write), status 0 (ok), whatever the user and error-level flags are, and no TLB request is made.
- R2: Outside identity, a user-mode request with address bit 31 set returns status 1 (bad address), physical address 0 and permission 0, with no TLB request.
- R3: Outside identity, a non-user address in 0x80000000–0xBFFFFFFF returns address AND 0x1FFFFFFF with permission 3 and status 0, regardless of the error-level flag.
- R4: In TLB scheme (select 0), an address in 0x00000000–0x7FFFFFFF with the error-level flag clear is sent to the TLB with its address and write flag; with the flag set it returns itself with permission 3 and status 0 and no TLB request.
- R5: In TLB scheme, addresses from 0xC0000000 to 0xFFFFFFFF are always sent to the TLB, whatever the error-level flag.
- R6: In fixed scheme (select 1), the user region returns address + 0x40000000 when the error-level flag is clear and the address itself when it is set; addresses from 0xC0000000 upward return themselves; all with permission 3, status 0, and never a TLB request.
- R7: A TLB answer (status code 0 hit, 1 miss, 2 invalid, 3 modified) is returned as block status 0, 2, 3 or 4 respectively, with the TLB's physical address and permission passed through unchanged.
- R8: A locally translated result has `rsp_valid` high for exactly the one cycle after acceptance; a TLB request has `tlb_req_valid` high for exactly the one cycle after acceptance; a TLB-path result has `rsp_valid` high for exactly the one cycle after the edge that sees `tlb_rsp_valid`.
- R9: `req_ready` is high only in IDLE; a `req_valid` raised while it is low is ignored and produces no response.
- R10: After reset, `req_ready` is high and `rsp_valid` and `tlb_req_valid` are low.
- R11: Scheme select 3 behaves as the TLB scheme.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request, taken when `req_ready` is high |
| req_ready | output | 1 | Block is idle and will take a request |
| req_vaddr | input | 32 | Virtual address |
| req_user | input | 1 | Requester runs in user mode |
| req_erl | input | 1 | Error-level flag |
| req_write | input | 1 | Access is a store |
| req_mode | input | 2 | Scheme: 0 TLB, 1 fixed, 2 identity, 3 as TLB |
| tlb_req_valid | output | 1 | One-cycle lookup pulse to the TLB |
| tlb_req_vaddr | output | 32 | Address to look up |
| tlb_req_write | output | 1 | Write flag for the lookup |
| tlb_rsp_valid | input | 1 | TLB answer is present |
| tlb_rsp_status | input | 2 | 0 hit, 1 miss, 2 invalid, 3 modified |
| tlb_rsp_paddr | input | 32 | Physical address from the TLB |
| tlb_rsp_perm | input | 2 | Permission from the TLB |
| rsp_valid | output | 1 | Result pulse |
| rsp_paddr | output | 32 | Physical address |
| rsp_perm | output | 2 | bit0 read, bit1 write |
| rsp_status | output | 3 | 0 ok, 1 bad address, 2 miss, 3 invalid, 4 modified |

## Verification
The bench probes each region boundary (0x7FFFFFFF, 0x80000000, 0xBFFFFFFF-side, 0xC0000000 and 0xE0000000) under every scheme, since a decoder that sliced the wrong address bits would push a kernel address into the TLB or mask a user address. It checks that identity ignores the user flag and that error level turns off only the user-region mapping, which a design with the priorities swapped would get wrong by issuing a lookup or reporting a bad address. It holds the TLB answer back for several cycles and raises a request while busy, where a controller that left IDLE too late or re-armed early would emit a second or early result. Each TLB status code is returned separately, so a mis-ordered recoding shows up as the wrong status number.

// File: rtl/vaseg_pkg.sv
package vaseg_pkg;

    localparam int VA_W   = 32;
    localparam int PERM_W = 2;

    typedef enum logic [1:0] {
        XM_TLB   = 2'd0,
        XM_FIXED = 2'd1,
        XM_IDENT = 2'd2,
        XM_ALT   = 2'd3
    } xmode_e;

    typedef enum logic [2:0] {
        XS_OK       = 3'd0,
        XS_BADADDR  = 3'd1,
        XS_MISS     = 3'd2,
        XS_INVALID  = 3'd3,
        XS_MODIFIED = 3'd4
    } xstat_e;

    typedef enum logic [1:0] {
        TS_HIT      = 2'd0,
        TS_MISS     = 2'd1,
        TS_INVALID  = 2'd2,
        TS_MODIFIED = 2'd3
    } tstat_e;

    typedef enum logic [1:0] {
        RG_USER,
        RG_DIRECT,
        RG_KMAP_LO,
        RG_KMAP_HI
    } region_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } fsm_e;

    localparam logic [PERM_W-1:0] PERM_RW   = 2'b11;
    localparam logic [PERM_W-1:0] PERM_NONE = 2'b00;

endpackage

// File: rtl/vaseg_region_decode.sv
module vaseg_region_decode
    import vaseg_pkg::*;
#(
    parameter int AW = VA_W
) (
    input  logic [AW-1:0] vaddr,
    output region_e       region
);
    localparam int TOP = 3;

    logic [TOP-1:0] top_bits;
    assign top_bits = vaddr[AW-1 -: TOP];

    always_comb begin
        unique casez (top_bits)
            3'b0??:  region = RG_USER;
            3'b10?:  region = RG_DIRECT;
            3'b110:  region = RG_KMAP_LO;
            default: region = RG_KMAP_HI;
        endcase
    end
endmodule

// File: rtl/vaseg_direct_map.sv
module vaseg_direct_map
    import vaseg_pkg::*;
#(
    parameter int            AW         = VA_W,
    parameter logic [AW-1:0] FIXED_OFS  = 32'h4000_0000,
    parameter logic [AW-1:0] UNMAP_MASK = 32'h1FFF_FFFF
) (
    input  logic [AW-1:0]     vaddr,
    input  region_e           region,
    input  xmode_e            mode,
    input  logic              user,
    input  logic              erl,
    output logic              need_tlb,
    output xstat_e            status,
    output logic [AW-1:0]     paddr,
    output logic [PERM_W-1:0] perm
);
    always_comb begin
        need_tlb = 1'b0;
        status   = XS_OK;
        paddr    = vaddr;
        perm     = PERM_RW;
        if (mode == XM_IDENT) begin
            need_tlb = 1'b0;
        end else if (user && (region != RG_USER)) begin
            status = XS_BADADDR;
            paddr  = '0;
            perm   = PERM_NONE;
        end else begin
            unique case (region)
                RG_USER: begin
                    if (!erl) begin
                        if (mode == XM_FIXED) paddr = vaddr + FIXED_OFS;
                        else                  need_tlb = 1'b1;
                    end
                end
                RG_DIRECT: paddr = vaddr & UNMAP_MASK;
                RG_KMAP_LO,
                RG_KMAP_HI: begin
                    if (mode != XM_FIXED) need_tlb = 1'b1;
                end
                default: need_tlb = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/vaseg_tlb_status_map.sv
module vaseg_tlb_status_map
    import vaseg_pkg::*;
(
    input  tstat_e tlb_status,
    output xstat_e status
);
    always_comb begin
        unique case (tlb_status)
            TS_HIT:      status = XS_OK;
            TS_MISS:     status = XS_MISS;
            TS_INVALID:  status = XS_INVALID;
            TS_MODIFIED: status = XS_MODIFIED;
            default:     status = XS_OK;
        endcase
    end
endmodule

// File: rtl/vaseg_xlate.sv
module vaseg_xlate
    import vaseg_pkg::*;
#(
    parameter int            AW         = VA_W,
    parameter logic [AW-1:0] FIXED_OFS  = 32'h4000_0000,
    parameter logic [AW-1:0] UNMAP_MASK = 32'h1FFF_FFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [AW-1:0]     req_vaddr,
    input  logic              req_user,
    input  logic              req_erl,
    input  logic              req_write,
    input  logic [1:0]        req_mode,
    output logic              tlb_req_valid,
    output logic [AW-1:0]     tlb_req_vaddr,
    output logic              tlb_req_write,
    input  logic              tlb_rsp_valid,
    input  logic [1:0]        tlb_rsp_status,
    input  logic [AW-1:0]     tlb_rsp_paddr,
    input  logic [PERM_W-1:0] tlb_rsp_perm,
    output logic              rsp_valid,
    output logic [AW-1:0]     rsp_paddr,
    output logic [PERM_W-1:0] rsp_perm,
    output logic [2:0]        rsp_status
);
    fsm_e state_q, state_d;

    region_e           region;
    logic              dm_need_tlb;
    xstat_e            dm_status;
    logic [AW-1:0]     dm_paddr;
    logic [PERM_W-1:0] dm_perm;
    xstat_e            tm_status;

    logic accept;
    logic tlb_done;

    vaseg_region_decode #(.AW(AW)) u_region (
        .vaddr  (req_vaddr),
        .region (region)
    );

    vaseg_direct_map #(
        .AW         (AW),
        .FIXED_OFS  (FIXED_OFS),
        .UNMAP_MASK (UNMAP_MASK)
    ) u_direct (
        .vaddr    (req_vaddr),
        .region   (region),
        .mode     (xmode_e'(req_mode)),
        .user     (req_user),
        .erl      (req_erl),
        .need_tlb (dm_need_tlb),
        .status   (dm_status),
        .paddr    (dm_paddr),
        .perm     (dm_perm)
    );

    vaseg_tlb_status_map u_tstat (
        .tlb_status (tstat_e'(tlb_rsp_status)),
        .status     (tm_status)
    );

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign tlb_done  = ((state_q == ST_ISSUE) || (state_q == ST_WAIT)) && tlb_rsp_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) state_d = dm_need_tlb ? ST_ISSUE : ST_DONE;
            end
            ST_ISSUE: state_d = tlb_rsp_valid ? ST_DONE : ST_WAIT;
            ST_WAIT:  state_d = tlb_rsp_valid ? ST_DONE : ST_WAIT;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tlb_req_valid <= 1'b0;
            tlb_req_vaddr <= '0;
            tlb_req_write <= 1'b0;
            rsp_valid     <= 1'b0;
            rsp_paddr     <= '0;
            rsp_perm      <= PERM_NONE;
            rsp_status    <= XS_OK;
        end else begin
            tlb_req_valid <= 1'b0;
            rsp_valid     <= 1'b0;
            if (accept) begin
                if (dm_need_tlb) begin
                    tlb_req_valid <= 1'b1;
                    tlb_req_vaddr <= req_vaddr;
                    tlb_req_write <= req_write;
                end else begin
                    rsp_valid  <= 1'b1;
                    rsp_paddr  <= dm_paddr;
                    rsp_perm   <= dm_perm;
                    rsp_status <= dm_status;
                end
            end else if (tlb_done) begin
                rsp_valid  <= 1'b1;
                rsp_paddr  <= tlb_rsp_paddr;
                rsp_perm   <= tlb_rsp_perm;
                rsp_status <= tm_status;
            end
        end
    end
endmodule

// File: rtl/vaseg_xlate_chk.sv
module vaseg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic        req_user,
    input logic        req_erl,
    input logic        req_write,
    input logic [1:0]  req_mode,
    input logic        tlb_req_valid,
    input logic [31:0] tlb_req_vaddr,
    input logic        tlb_req_write,
    input logic        tlb_rsp_valid,
    input logic [1:0]  tlb_rsp_status,
    input logic [31:0] tlb_rsp_paddr,
    input logic [1:0]  tlb_rsp_perm,
    input logic        rsp_valid,
    input logic [31:0] rsp_paddr,
    input logic [1:0]  rsp_perm,
    input logic [2:0]  rsp_status
);
    a_r1_identity: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode == 2'd2) |=>
        (rsp_valid && !tlb_req_valid && rsp_paddr == $past(req_vaddr) &&
         rsp_perm == 2'b11 && rsp_status == 3'd0));

    a_r2_user_bad: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode != 2'd2 && req_user && req_vaddr[31]) |=>
        (rsp_valid && !tlb_req_valid && rsp_status == 3'd1 && rsp_perm == 2'b00));

    a_r3_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_mode != 2'd2 && !req_user && req_vaddr[31:30] == 2'b10) |=>
        (rsp_valid && rsp_paddr == ($past(req_vaddr) & 32'h1FFF_FFFF) && rsp_status == 3'd0));

    a_r7_tlb_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_rsp_valid && !req_ready && !rsp_valid) |=>
        (rsp_valid && rsp_paddr == $past(tlb_rsp_paddr) && rsp_perm == $past(tlb_rsp_perm)));

    a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req_valid |=> !tlb_req_valid);

    a_r8_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r9_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || tlb_req_valid) |-> !req_ready);
endmodule

bind vaseg_xlate vaseg_xlate_chk chk_i (.*);

// File: tb/vaseg_xlate_tb_top.sv
module vaseg_xlate_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_user = 1'b0;
    logic        req_erl = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_mode = 2'd0;
    logic        tlb_req_valid;
    logic [31:0] tlb_req_vaddr;
    logic        tlb_req_write;
    logic        tlb_rsp_valid = 1'b0;
    logic [1:0]  tlb_rsp_status = '0;
    logic [31:0] tlb_rsp_paddr = '0;
    logic [1:0]  tlb_rsp_perm = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_perm;
    logic [2:0]  rsp_status;

    int checks = 0;
    int errs   = 0;

    always #2 clk = ~clk;

    vaseg_xlate dut_i (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [1:0] m, input logic u, input logic e,
                        input logic w, input logic [31:0] va);
        @(negedge clk);
        req_mode = m; req_user = u; req_erl = e; req_write = w; req_vaddr = va;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic direct_case(input string tag, input logic [1:0] m, input logic u,
                               input logic e, input logic [31:0] va, input logic [2:0] est,
                               input logic [31:0] epa, input logic [1:0] eperm);
        send(m, u, e, 1'b0, va);
        chk({tag, " rsp_valid"}, rsp_valid, 1);
        chk({tag, " no lookup"}, tlb_req_valid, 0);
        chk({tag, " status"}, rsp_status, est);
        chk({tag, " paddr"}, rsp_paddr, epa);
        chk({tag, " perm"}, rsp_perm, eperm);
        @(negedge clk);
        chk({tag, " R8 pulse end"}, rsp_valid, 0);
        chk({tag, " R9 ready back"}, req_ready, 1);
    endtask

    task automatic tlb_case(input string tag, input logic [1:0] m, input logic u,
                            input logic e, input logic w, input logic [31:0] va,
                            input int delay, input logic [1:0] ts,
                            input logic [31:0] tpa, input logic [1:0] tperm,
                            input logic [2:0] est);
        send(m, u, e, w, va);
        chk({tag, " lookup"}, tlb_req_valid, 1);
        chk({tag, " lookup addr"}, tlb_req_vaddr, va);
        chk({tag, " lookup write"}, tlb_req_write, w);
        chk({tag, " R9 busy"}, req_ready, 0);
        for (int i = 0; i < delay; i++) begin
            @(negedge clk);
            chk({tag, " R8 no early rsp"}, rsp_valid, 0);
            chk({tag, " R8 lookup single"}, tlb_req_valid, 0);
        end
        tlb_rsp_status = ts; tlb_rsp_paddr = tpa; tlb_rsp_perm = tperm;
        tlb_rsp_valid = 1'b1;
        @(negedge clk);
        tlb_rsp_valid = 1'b0;
        chk({tag, " R8 rsp_valid"}, rsp_valid, 1);
        chk({tag, " R7 status"}, rsp_status, est);
        chk({tag, " R7 paddr"}, rsp_paddr, tpa);
        chk({tag, " R7 perm"}, rsp_perm, tperm);
        @(negedge clk);
        chk({tag, " R8 pulse end"}, rsp_valid, 0);
        chk({tag, " R9 ready back"}, req_ready, 1);
    endtask

    task automatic t_reset;
        chk("R10 ready", req_ready, 1);
        chk("R10 rsp_valid", rsp_valid, 0);
        chk("R10 tlb_req_valid", tlb_req_valid, 0);
    endtask

    task automatic t_identity;
        direct_case("R1 kernel hi", 2'd2, 1'b0, 1'b0, 32'hC000_1234, 3'd0, 32'hC000_1234, 2'b11);
        direct_case("R1 user ignores", 2'd2, 1'b1, 1'b1, 32'h8000_0010, 3'd0, 32'h8000_0010, 2'b11);
    endtask

    task automatic t_user_bad;
        direct_case("R2 tlb scheme", 2'd0, 1'b1, 1'b0, 32'h8000_1000, 3'd1, 32'h0, 2'b00);
        direct_case("R2 fixed scheme", 2'd1, 1'b1, 1'b0, 32'hFFFF_0000, 3'd1, 32'h0, 2'b00);
    endtask

    task automatic t_unmapped;
        direct_case("R3 low window", 2'd0, 1'b0, 1'b0, 32'h9234_5678, 3'd0, 32'h1234_5678, 2'b11);
        direct_case("R3 erl fixed", 2'd1, 1'b0, 1'b1, 32'hBFC0_0000, 3'd0, 32'h1FC0_0000, 2'b11);
        direct_case("R3 boundary", 2'd0, 1'b0, 1'b0, 32'h8000_0000, 3'd0, 32'h0000_0000, 2'b11);
    endtask

    task automatic t_tlb_user;
        tlb_case("R4 useg", 2'd0, 1'b1, 1'b0, 1'b1, 32'h0040_1000, 0, 2'd0, 32'h0ABC_D000, 2'b11, 3'd0);
        direct_case("R4 useg erl", 2'd0, 1'b0, 1'b1, 32'h0040_1000, 3'd0, 32'h0040_1000, 2'b11);
        tlb_case("R4 useg top", 2'd0, 1'b0, 1'b0, 1'b0, 32'h7FFF_FFFF, 2, 2'd0, 32'h0000_0FFF, 2'b01, 3'd0);
    endtask

    task automatic t_tlb_upper;
        tlb_case("R5 kmap lo", 2'd0, 1'b0, 1'b0, 1'b0, 32'hC000_2000, 1, 2'd0, 32'h0100_0000, 2'b01, 3'd0);
        tlb_case("R5 kmap hi erl", 2'd0, 1'b0, 1'b1, 1'b1, 32'hE000_0004, 0, 2'd0, 32'h0200_0004, 2'b11, 3'd0);
    endtask

    task automatic t_fixed;
        direct_case("R6 offset", 2'd1, 1'b0, 1'b0, 32'h1000_0000, 3'd0, 32'h5000_0000, 2'b11);
        direct_case("R6 offset top", 2'd1, 1'b1, 1'b0, 32'h7FFF_FFFF, 3'd0, 32'hBFFF_FFFF, 2'b11);
        direct_case("R6 erl", 2'd1, 1'b0, 1'b1, 32'h1000_0000, 3'd0, 32'h1000_0000, 2'b11);
        direct_case("R6 kmap lo", 2'd1, 1'b0, 1'b0, 32'hD000_0000, 3'd0, 32'hD000_0000, 2'b11);
        direct_case("R6 kmap hi", 2'd1, 1'b0, 1'b0, 32'hF000_0000, 3'd0, 32'hF000_0000, 2'b11);
    endtask

    task automatic t_status;
        tlb_case("R7 miss", 2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_8000, 0, 2'd1, 32'h0000_1111, 2'b00, 3'd2);
        tlb_case("R7 invalid", 2'd0, 1'b0, 1'b0, 1'b0, 32'hC800_0000, 1, 2'd2, 32'h0000_2222, 2'b01, 3'd3);
        tlb_case("R7 modified", 2'd0, 1'b0, 1'b0, 1'b1, 32'hF800_0000, 3, 2'd3, 32'h0000_3333, 2'b01, 3'd4);
    endtask

    task automatic t_busy;
        send(2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_4000);
        chk("R9 lookup issued", tlb_req_valid, 1);
        @(negedge clk);
        req_mode = 2'd2; req_vaddr = 32'h0000_1234; req_valid = 1'b1;
        @(negedge clk);
        chk("R9 busy no rsp", rsp_valid, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 busy no rsp 2", rsp_valid, 0);
        tlb_rsp_status = 2'd1; tlb_rsp_paddr = 32'h0000_5555; tlb_rsp_perm = 2'b00;
        tlb_rsp_valid = 1'b1;
        @(negedge clk);
        tlb_rsp_valid = 1'b0;
        chk("R9 rsp is lookup's", rsp_paddr, 32'h0000_5555);
        chk("R9 rsp status", rsp_status, 3'd2);
        @(negedge clk);
        chk("R9 no late rsp", rsp_valid, 0);
        @(negedge clk);
        chk("R9 no late rsp 2", rsp_valid, 0);
        chk("R9 idle", req_ready, 1);
    endtask

    task automatic t_mode3;
        tlb_case("R11 useg", 2'd3, 1'b0, 1'b0, 1'b0, 32'h0000_4000, 0, 2'd0, 32'h0003_4000, 2'b11, 3'd0);
        tlb_case("R11 kmap", 2'd3, 1'b0, 1'b0, 1'b0, 32'hC000_0000, 1, 2'd0, 32'h0004_0000, 2'b01, 3'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_user_bad();
        t_unmapped();
        t_tlb_user();
        t_tlb_upper();
        t_fixed();
        t_status();
        t_busy();
        t_mode3();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errs++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule